// File: doc/BRIEF.md
# Memory-to-Memory Vector Stream Engine

This engine carries out one integer vector operation per command, moving the operands straight from memory to memory with no vector register file in between. A command names two source base addresses, a destination base address, an element count and an operation. The engine then walks both sources through two independent read ports and the destination through one write port, one 128-bit beat per address. Elements within a beat occupy the low bits first.

Returning read data lands in two read buffers. Operand beats leave the buffers in pairs and pass through a multi-stage adder/subtractor pipeline. A write buffer holds the results until the write port accepts them. Fetching runs ahead of the arithmetic, so once the pipeline has filled it accepts one beat per cycle. The cost is a fixed startup delay before the first write.

The 64-bit slots of the datapath either hold one 64-bit element each or split into two independent 32-bit lanes. Split mode doubles the number of elements carried per beat.

Top module: `vse_stream_engine`

## Requirements
- R1: A `start` pulse while idle with a nonzero `count` captures the command and raises `busy`. A `start` pulse while `busy` is high is ignored: it touches no address and does not change the run in progress.
- R2: Each read port issues exactly B requests, where B = ceil(count * E / 16) and E is 8 bytes in 64-bit mode or 4 bytes in split mode. The addresses run base, base+1, and so on up to base+B-1.
- R3: In 64-bit mode (`split`=0), element k sits at bits [64*(k mod 2) +: 64] of beat k/2. `op`=0 gives a+b and `op`=1 gives a-b, both modulo 2^64.
- R4: In split mode (`split`=1), element k sits at bits [32*(k mod 4) +: 32] of beat k/4. The arithmetic is modulo 2^32 in each lane, and no carry or borrow crosses between lanes.
- R5: For each read port, requests accepted but not yet consumed by the arithmetic never exceed RBUF_DEPTH. When responses are withheld, exactly RBUF_DEPTH requests are accepted on each port before issue stops.
- R6: Exactly B writes are issued, one per beat, in order to the addresses dst, dst+1, and so on up to dst+B-1.
- R7: Every write except the last carries an all-ones `wr_strb`. On the last write, strobe bit i is set for each byte i below (count*E mod 16), or every bit is set when that value is 0. Bytes whose strobe bit is clear keep their old memory contents.
- R8: Any request held with valid high and ready low keeps its address, and its data in the case of writes, until it is accepted. Random back-pressure on every port neither loses nor duplicates an element.
- R9: `done` is high for exactly one cycle per command. That cycle is the one after the edge at which the last write is accepted, and `busy` is low in it.
- R10: A `start` with `count`=0 issues no request and raises `done` in the cycle after the start edge.
- R11: With no back-pressure and single-cycle memory, a run of B beats completes within B+16 cycles of the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe |
| op | input | 1 | 0 = add, 1 = subtract (a - b) |
| split | input | 1 | 1 = two 32-bit lanes per 64-bit slot |
| count | input | LEN_W | Element count |
| src_a_base | input | AW | First source base beat address |
| src_b_base | input | AW | Second source base beat address |
| dst_base | input | AW | Destination base beat address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ra_req_valid | output | 1 | Source A request valid |
| ra_req_ready | input | 1 | Source A request accepted |
| ra_req_addr | output | AW | Source A beat address |
| ra_rsp_valid | input | 1 | Source A read data valid |
| ra_rsp_ready | output | 1 | Source A buffer can take data |
| ra_rsp_data | input | BEAT_W | Source A read data |
| rb_req_valid | output | 1 | Source B request valid |
| rb_req_ready | input | 1 | Source B request accepted |
| rb_req_addr | output | AW | Source B beat address |
| rb_rsp_valid | input | 1 | Source B read data valid |
| rb_rsp_ready | output | 1 | Source B buffer can take data |
| rb_rsp_data | input | BEAT_W | Source B read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | AW | Destination beat address |
| wr_data | output | BEAT_W | Result beat |
| wr_strb | output | BEAT_W/8 | Byte enables |

## Verification
The embedded properties assume three things about the environment:
- Read responses on each port return in request order, one per accepted request.
- A response is never presented without a request before it.
- No `start` falls inside the reset.

The bench's memory model keeps a first-in first-out queue of accepted addresses for each port and answers only from the head of that queue. It asserts `start` only after reset has been released. With back-pressure enabled, it toggles ready and response valid at random on every port, and in one scenario it withholds responses entirely so that the credit limit is reached.

// File: rtl/vse_pkg.sv
package vse_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } vse_op_e;

  // One 64-bit slot: a single 64-bit element or two independent 32-bit lanes.
  function automatic logic [63:0] slot_calc(input logic [63:0] a,
                                            input logic [63:0] b,
                                            input vse_op_e     op,
                                            input logic        split);
    logic [63:0] r;
    if (split) begin
      r[31:0]  = (op == OP_SUB) ? a[31:0]  - b[31:0]  : a[31:0]  + b[31:0];
      r[63:32] = (op == OP_SUB) ? a[63:32] - b[63:32] : a[63:32] + b[63:32];
    end else begin
      r = (op == OP_SUB) ? a - b : a + b;
    end
    return r;
  endfunction

endpackage

// File: rtl/vse_fifo.sv
module vse_fifo #(
  parameter int W     = 128,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  // Storage without reset so a distributed RAM can be inferred.
  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);

endmodule

// File: rtl/vse_rd_port.sv
module vse_rd_port #(
  parameter int AW    = 16,
  parameter int DW    = 128,
  parameter int DEPTH = 4,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    base,
  input  logic [LEN_W-1:0] beats,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [DW-1:0]    rsp_data,
  input  logic             pop,
  output logic [DW-1:0]    dout,
  output logic             empty
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [LEN_W-1:0] left;
  logic [CW-1:0]    owed;   // accepted requests not yet consumed
  logic             fire, full;

  assign fire      = req_valid && req_ready;
  assign req_valid = (left != '0) && (owed < CW'(DEPTH));
  assign rsp_ready = !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      left     <= '0;
      owed     <= '0;
      req_addr <= '0;
    end else begin
      if (load) begin
        req_addr <= base;
        left     <= beats;
      end else if (fire) begin
        req_addr <= req_addr + 1'b1;
        left     <= left - 1'b1;
      end
      case ({fire, pop})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  vse_fifo #(.W(DW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst),
    .push(rsp_valid && rsp_ready), .din(rsp_data),
    .pop(pop), .dout(dout), .full(full), .empty(empty)
  );

  a_r5_credit_bound: assert property (@(posedge clk) disable iff (rst) owed <= CW'(DEPTH));
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    fire |=> !req_valid || (req_addr == $past(req_addr) + 1'b1));

endmodule

// File: rtl/vse_alu_pipe.sv
module vse_alu_pipe #(
  parameter int BEAT_W = 128,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [BEAT_W-1:0] a,
  input  logic [BEAT_W-1:0] b,
  input  vse_pkg::vse_op_e  op,
  input  logic              split,
  output logic              out_valid,
  output logic              out_last,
  output logic [BEAT_W-1:0] out_data
);
  localparam int SLOTS = BEAT_W / 64;

  logic [BEAT_W-1:0] calc;
  logic [BEAT_W-1:0] d [STAGES];
  logic [STAGES-1:0] v, l;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign calc[s*64 +: 64] = vse_pkg::slot_calc(a[s*64 +: 64], b[s*64 +: 64], op, split);
  end

  always_ff @(posedge clk) begin
    if (rst) v <= '0;
    else if (adv) v <= {v[STAGES-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      d[0] <= calc;
      l[0] <= in_last;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (adv) begin
        d[i] <= d[i-1];
        l[i] <= l[i-1];
      end
    end
  end

  assign out_valid = v[STAGES-1];
  assign out_last  = l[STAGES-1];
  assign out_data  = d[STAGES-1];

endmodule

// File: rtl/vse_stream_engine.sv
module vse_stream_engine #(
  parameter int AW          = 16,
  parameter int LEN_W       = 16,
  parameter int BEAT_W      = 128,
  parameter int RBUF_DEPTH  = 4,
  parameter int WBUF_DEPTH  = 4,
  parameter int PIPE_STAGES = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                op,
  input  logic                split,
  input  logic [LEN_W-1:0]    count,
  input  logic [AW-1:0]       src_a_base,
  input  logic [AW-1:0]       src_b_base,
  input  logic [AW-1:0]       dst_base,
  output logic                busy,
  output logic                done,
  output logic                ra_req_valid,
  input  logic                ra_req_ready,
  output logic [AW-1:0]       ra_req_addr,
  input  logic                ra_rsp_valid,
  output logic                ra_rsp_ready,
  input  logic [BEAT_W-1:0]   ra_rsp_data,
  output logic                rb_req_valid,
  input  logic                rb_req_ready,
  output logic [AW-1:0]       rb_req_addr,
  input  logic                rb_rsp_valid,
  output logic                rb_rsp_ready,
  input  logic [BEAT_W-1:0]   rb_rsp_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [AW-1:0]       wr_addr,
  output logic [BEAT_W-1:0]   wr_data,
  output logic [BEAT_W/8-1:0] wr_strb
);
  import vse_pkg::*;

  localparam int NBYTE = BEAT_W / 8;
  localparam int BB_W  = $clog2(NBYTE);
  localparam int NB_W  = LEN_W + BB_W;
  localparam int WB_W  = BEAT_W + NBYTE;

  vse_op_e          op_q;
  logic             split_q;
  logic [LEN_W-1:0] beats_q, issued, written;
  logic [NBYTE-1:0] tail_strb;

  logic [NB_W-1:0]  nbytes;
  logic [LEN_W-1:0] beats_calc;
  logic [BB_W-1:0]  tail;
  logic [NBYTE-1:0] strb_calc;
  logic             start_ok, start_zero;

  // Command decode: byte total, beat count and tail strobe.
  always_comb begin
    nbytes     = {{BB_W{1'b0}}, count} << (split ? 2 : 3);
    beats_calc = nbytes[NB_W-1:BB_W] + LEN_W'(nbytes[BB_W-1:0] != '0);
    tail       = nbytes[BB_W-1:0];
    strb_calc  = (tail == '0) ? '1 : (NBYTE'(1) << tail) - NBYTE'(1);
  end

  assign start_ok   = start && !busy && (count != '0);
  assign start_zero = start && !busy && (count == '0);

  // Read side
  logic              a_empty, b_empty, issue;
  logic [BEAT_W-1:0] a_dat, b_dat;

  vse_rd_port #(.AW(AW), .DW(BEAT_W), .DEPTH(RBUF_DEPTH), .LEN_W(LEN_W)) u_rd_a (
    .clk(clk), .rst(rst), .load(start_ok), .base(src_a_base), .beats(beats_calc),
    .req_valid(ra_req_valid), .req_ready(ra_req_ready), .req_addr(ra_req_addr),
    .rsp_valid(ra_rsp_valid), .rsp_ready(ra_rsp_ready), .rsp_data(ra_rsp_data),
    .pop(issue), .dout(a_dat), .empty(a_empty)
  );

  vse_rd_port #(.AW(AW), .DW(BEAT_W), .DEPTH(RBUF_DEPTH), .LEN_W(LEN_W)) u_rd_b (
    .clk(clk), .rst(rst), .load(start_ok), .base(src_b_base), .beats(beats_calc),
    .req_valid(rb_req_valid), .req_ready(rb_req_ready), .req_addr(rb_req_addr),
    .rsp_valid(rb_rsp_valid), .rsp_ready(rb_rsp_ready), .rsp_data(rb_rsp_data),
    .pop(issue), .dout(b_dat), .empty(b_empty)
  );

  // Arithmetic: the whole pipeline freezes while the write buffer is full.
  logic              wb_full, wb_empty, adv;
  logic              p_valid, p_last;
  logic [BEAT_W-1:0] p_data;

  assign adv   = !wb_full;
  assign issue = busy && (issued != beats_q) && !a_empty && !b_empty && adv;

  vse_alu_pipe #(.BEAT_W(BEAT_W), .STAGES(PIPE_STAGES)) u_alu (
    .clk(clk), .rst(rst), .adv(adv), .in_valid(issue),
    .in_last(issued == beats_q - 1'b1), .a(a_dat), .b(b_dat),
    .op(op_q), .split(split_q),
    .out_valid(p_valid), .out_last(p_last), .out_data(p_data)
  );

  // Write side
  logic             wr_fire;
  logic [WB_W-1:0]  wb_out;

  vse_fifo #(.W(WB_W), .DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk(clk), .rst(rst),
    .push(p_valid && adv), .din({(p_last ? tail_strb : {NBYTE{1'b1}}), p_data}),
    .pop(wr_fire), .dout(wb_out), .full(wb_full), .empty(wb_empty)
  );

  assign wr_valid = !wb_empty;
  assign wr_fire  = wr_valid && wr_ready;
  assign wr_data  = wb_out[BEAT_W-1:0];
  assign wr_strb  = wb_out[WB_W-1:BEAT_W];

  // Control
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      issued  <= '0;
      written <= '0;
      beats_q <= '0;
      wr_addr <= '0;
      op_q    <= OP_ADD;
      split_q <= 1'b0;
      tail_strb <= '0;
    end else begin
      done <= start_zero || (wr_fire && (written == beats_q - 1'b1));
      if (start_ok) begin
        busy      <= 1'b1;
        issued    <= '0;
        written   <= '0;
        beats_q   <= beats_calc;
        wr_addr   <= dst_base;
        op_q      <= vse_op_e'(op);
        split_q   <= split;
        tail_strb <= strb_calc;
      end else begin
        if (issue) issued <= issued + 1'b1;
        if (wr_fire) begin
          written <= written + 1'b1;
          wr_addr <= wr_addr + 1'b1;
          if (written == beats_q - 1'b1) busy <= 1'b0;
        end
      end
    end
  end

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r6_write_bound: assert property (@(posedge clk) disable iff (rst) busy |-> written < beats_q);
  a_r8_wr_hold: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb));
  a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
    wb_full && p_valid |=> p_valid && $stable(p_data));

endmodule

// File: tb/vse_stream_engine_test.sv
`timescale 1ns/1ps
module vse_stream_engine_test;
  localparam int AW = 16, LEN_W = 16, BEAT_W = 128, RBUF = 4;
  localparam logic [127:0] SENT = {16{8'hA5}};
  localparam logic [15:0] A_BASE = 16'd0, B_BASE = 16'd64, D_BASE = 16'd128;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, op = 0, split = 0;
  logic [LEN_W-1:0] count = 0;
  logic [AW-1:0] src_a_base = 0, src_b_base = 0, dst_base = 0;
  logic busy, done;
  logic ra_req_valid, ra_req_ready = 0, ra_rsp_valid = 0, ra_rsp_ready;
  logic rb_req_valid, rb_req_ready = 0, rb_rsp_valid = 0, rb_rsp_ready;
  logic [AW-1:0] ra_req_addr, rb_req_addr, wr_addr;
  logic [BEAT_W-1:0] ra_rsp_data = 0, rb_rsp_data = 0, wr_data;
  logic wr_valid, wr_ready = 0;
  logic [BEAT_W/8-1:0] wr_strb;

  always #2.5 clk = ~clk;

  vse_stream_engine uut (.*);

  logic [127:0] mem [256];
  logic [AW-1:0] qa[$], qb[$];
  int checks = 0, fails = 0, cyc = 0;
  int reqa, reqb, wcnt, dcnt, ord_err, last_w_cyc, done_cyc, start_cyc;
  logic [AW-1:0] exp_a, exp_b, exp_w;
  bit bp = 0, hold = 0;

  // Memory model: sample at the rising edge, respond at the falling edge.
  initial begin
    forever begin
      bit fa, fb, ga, gb, fw, dn, st;
      logic [AW-1:0] aa, ab, aw;
      logic [127:0] wd;
      logic [15:0] ws;
      @(posedge clk);
      cyc++;
      fa = ra_req_valid && ra_req_ready; aa = ra_req_addr;
      fb = rb_req_valid && rb_req_ready; ab = rb_req_addr;
      ga = ra_rsp_valid && ra_rsp_ready;
      gb = rb_rsp_valid && rb_rsp_ready;
      fw = wr_valid && wr_ready; aw = wr_addr; wd = wr_data; ws = wr_strb;
      dn = done; st = start && !rst;
      @(negedge clk);
      if (ga) void'(qa.pop_front());
      if (gb) void'(qb.pop_front());
      if (fa) begin qa.push_back(aa); reqa++; if (aa != exp_a) ord_err++; exp_a = exp_a + 1; end
      if (fb) begin qb.push_back(ab); reqb++; if (ab != exp_b) ord_err++; exp_b = exp_b + 1; end
      if (fw) begin
        for (int i = 0; i < 16; i++) if (ws[i]) mem[aw[7:0]][i*8 +: 8] = wd[i*8 +: 8];
        wcnt++; last_w_cyc = cyc;
        if (aw != exp_w) ord_err++;
        exp_w = exp_w + 1;
      end
      if (dn) begin dcnt++; done_cyc = cyc; end
      if (st) start_cyc = cyc;
      ra_req_ready = bp ? 1'($urandom % 2) : 1'b1;
      rb_req_ready = bp ? 1'($urandom % 2) : 1'b1;
      wr_ready     = bp ? 1'($urandom % 2) : 1'b1;
      ra_rsp_valid = !hold && qa.size() > 0 && (bp ? 1'($urandom % 2) : 1'b1);
      rb_rsp_valid = !hold && qb.size() > 0 && (bp ? 1'($urandom % 2) : 1'b1);
      ra_rsp_data  = (qa.size() > 0) ? mem[qa[0][7:0]] : '0;
      rb_rsp_data  = (qb.size() > 0) ? mem[qb[0][7:0]] : '0;
    end
  end

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbeats(int n, bit sp);
    return (n * (sp ? 4 : 8) + 15) / 16;
  endfunction

  task automatic prep();
    @(posedge clk); #1;
    for (int i = 0; i < 128; i++) mem[i] = {$urandom, $urandom, $urandom, $urandom};
    for (int i = 128; i < 256; i++) mem[i] = SENT;
    reqa = 0; reqb = 0; wcnt = 0; dcnt = 0; ord_err = 0;
    last_w_cyc = -1; done_cyc = -1; start_cyc = -1;
    exp_a = A_BASE; exp_b = B_BASE; exp_w = D_BASE;
  endtask

  task automatic pulse_start(bit o, bit sp, int n, logic [AW-1:0] d);
    @(posedge clk); #1;
    op = o; split = sp; count = LEN_W'(n);
    src_a_base = A_BASE; src_b_base = B_BASE; dst_base = d;
    start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && dcnt == 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  // Compare the destination region (plus one beat past it) with values computed here.
  task automatic verify(bit o, bit sp, int n, string tag);
    int b = nbeats(n, sp);
    int ew = sp ? 32 : 64;
    int epb = 128 / ew;
    logic [127:0] m = sp ? 128'hFFFF_FFFF : {64'b0, {64{1'b1}}};
    int bad = 0;
    logic [127:0] fa = 0, fe = 0;
    for (int j = 0; j <= b; j++) begin
      logic [127:0] e = SENT;
      for (int s = 0; s < epb; s++) begin
        int k = j * epb + s;
        if (k < n) begin
          logic [127:0] x = (mem[A_BASE + j] >> (s * ew)) & m;
          logic [127:0] y = (mem[B_BASE + j] >> (s * ew)) & m;
          logic [127:0] r = (o ? x - y : x + y) & m;
          e = (e & ~(m << (s * ew))) | (r << (s * ew));
        end
      end
      if (mem[D_BASE + j] !== e && bad == 0) begin bad = 1; fa = mem[D_BASE + j]; fe = e; end
    end
    check(bad == 0, {tag, " data R3 R4 R7"}, fa, fe);
    check(reqa == b && reqb == b, {tag, " R2 read count"}, 128'(reqa + reqb), 128'(2 * b));
    check(wcnt == b, {tag, " R6 write count"}, 128'(wcnt), 128'(b));
    check(ord_err == 0, {tag, " R2 R6 R8 address order"}, 128'(ord_err), 0);
    check(dcnt == 1, {tag, " R9 done pulses"}, 128'(dcnt), 1);
    check(done_cyc == last_w_cyc + 1, {tag, " R9 done timing"}, 128'(done_cyc), 128'(last_w_cyc + 1));
    check(busy == 0, {tag, " R9 idle after done"}, 128'(busy), 0);
  endtask

  task automatic t_reset();
    #1;
    check(!busy && !done && !wr_valid && !ra_req_valid && !rb_req_valid,
          "reset R1 R9 idle outputs", {busy, done, wr_valid, ra_req_valid}, 0);
  endtask

  task automatic run(bit o, bit sp, int n, bit use_bp, string tag);
    bp = use_bp;
    prep();
    pulse_start(o, sp, n, D_BASE);
    wait_done();
    verify(o, sp, n, tag);
    bp = 0;
  endtask

  task automatic t_zero();
    prep();
    pulse_start(0, 0, 0, D_BASE);
    repeat (6) @(posedge clk); #1;
    check(done_cyc == start_cyc + 1, "R10 zero-count done timing", 128'(done_cyc), 128'(start_cyc + 1));
    check(reqa == 0 && reqb == 0 && wcnt == 0, "R10 zero-count no traffic", 128'(reqa + reqb + wcnt), 0);
  endtask

  task automatic t_credit();
    hold = 1;
    prep();
    pulse_start(0, 0, 40, D_BASE);
    repeat (30) @(posedge clk); #1;
    check(reqa == RBUF, "R5 credit limit port A", 128'(reqa), 128'(RBUF));
    check(reqb == RBUF, "R5 credit limit port B", 128'(reqb), 128'(RBUF));
    pulse_start(1, 1, 5, 16'd200);
    hold = 0;
    wait_done();
    verify(0, 0, 40, "credit");
    check(mem[200] == SENT, "R1 start while busy ignored", mem[200], SENT);
  endtask

  task automatic t_rate();
    prep();
    pulse_start(0, 0, 64, D_BASE);
    wait_done();
    verify(0, 0, 64, "rate");
    check(done_cyc - start_cyc <= 32 + 16, "R11 steady throughput",
          128'(done_cyc - start_cyc), 128'(48));
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 0;
    t_reset();
    run(0, 0, 7, 0, "add64 R3");
    run(1, 0, 16, 1, "sub64 R3 R8");
    run(0, 1, 13, 0, "add32 R4 R7");
    run(1, 1, 101, 1, "sub32 R4 R8");
    run(1, 1, 1, 0, "single R7");
    t_zero();
    t_credit();
    t_rate();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule